// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. It is clocked by the system clock and advanced by a one-clock sample tick that runs at sixteen times the baud rate. The incoming line is synchronized first. The receiver then waits for a low level that lasts long enough to count as a start bit, and treats shorter dips as noise.

Once a start bit is accepted, the receiver times every later sample from the tick on which the line was first seen low. Each data bit is read once near its centre. After that come an optional parity bit and one stop bit. The assembled character is presented on a parallel output with a one-clock valid strobe. A parity-error flag and a framing-error flag are presented alongside it. Characters may follow one another with a single stop bit and no idle gap.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset the valid strobe, both error flags and the data output are 0, and the line is taken as idle high.
- R2: A start bit is accepted only if the synchronized line is low on at least 8 consecutive sample ticks (more than 7 of 16), counted from the first tick on which it is seen low.
- R3: A low pulse seen on 7 or fewer ticks produces no character, and the receiver returns to waiting for a start bit.
- R4: Counting the first low tick as tick 0, data bit k (k = 0..7) is sampled exactly once, on tick 24 + 16k. Bits arrive least significant first, so bit k lands in data output bit k.
- R5: The character is presented with a valid strobe that lasts exactly one clock. It is issued in the clock after the tick that samples the stop bit. The data and flags hold their values until the next strobe.
- R6: When parity is enabled, the bit after D7 is the parity bit and the stop bit follows it. With the odd select at 0, the eight data bits plus the parity bit must hold an even number of ones. With the odd select at 1, they must hold an odd number. A mismatch sets the parity-error flag. When parity is disabled, the stop bit follows D7 and the parity-error flag is 0.
- R7: A stop-bit sample of 0 sets the framing-error flag. After that, no new start bit is armed until the line has been seen high.
- R8: After the stop-bit sample the receiver goes straight back to waiting for a start bit, so characters sent back to back with one stop bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | One-clock sample enable at 16x the baud rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | 1 = a parity bit follows the data bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | One-clock strobe for a new character |
| rx_perr | output | 1 | Parity mismatch for the presented character |
| rx_ferr | output | 1 | Stop bit sampled low for the presented character |

## Verification
The assertions assume that smp_tick is a single-clock pulse separated by idle clocks. They also assume that characters arrive at least a full frame apart, so one valid strobe can never follow the previous one directly. They further assume that par_en and par_odd stay constant from the start bit until the stop bit. The stimulus meets these conditions: it spaces ticks four clocks apart, changes the line only on whole tick multiples, and changes the parity settings only before a start bit is sent.

// File: rtl/osr_uart_rx_pkg.sv
package osr_uart_rx_pkg;

  localparam int unsigned RX_MAX_W = 16;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_START  = 2'd1,
    ST_FRAME  = 2'd2,
    ST_WAIT_HI = 2'd3
  } rx_state_e;

  // parity bit a transmitter places after the data for the chosen sense
  function automatic logic exp_parity(input logic [RX_MAX_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // slot index of the stop bit: slot 0 is the start bit, then data, then parity
  function automatic int unsigned stop_slot(input logic pen, input int unsigned dw);
    return dw + 1 + (pen ? 1 : 0);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_timer.sv
module rx_tick_timer #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic at_mid,
  output logic at_qual_end
);
  localparam int unsigned PH_W = $clog2(OSR);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= PH_W'(1);
    else if (tick)    phase <= (phase == PH_W'(OSR-1)) ? '0 : phase + PH_W'(1);
  end

  assign at_mid      = (phase == PH_W'(OSR/2));
  assign at_qual_end = (phase == PH_W'(OSR/2 - 1));
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {bit_in, word[DATA_W-1:1]};
  end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_perr,
  output logic              rx_ferr
);
  localparam int unsigned SLOT_W = $clog2(DATA_W + 3);
  localparam int unsigned LR_W   = $clog2(OSR + 1);

  rx_state_e st, st_nx;
  logic rx_s, at_mid, at_qual_end;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] word;
  logic pen_q, podd_q, par_bit_q;

  // named internal events
  logic hunt_edge, accept_evt, glitch_evt, bit_smp, data_smp, par_smp, stop_smp;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  rx_tick_timer #(.OSR(OSR)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(hunt_edge), .tick(smp_tick),
    .at_mid(at_mid), .at_qual_end(at_qual_end)
  );

  rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(data_smp), .bit_in(rx_s), .word(word)
  );

  assign hunt_edge  = (st == ST_HUNT)  && smp_tick && !rx_s;
  assign glitch_evt = (st == ST_START) && smp_tick && rx_s;
  assign accept_evt = (st == ST_START) && smp_tick && !rx_s && at_qual_end;
  assign bit_smp    = (st == ST_FRAME) && smp_tick && at_mid;
  assign data_smp   = bit_smp && (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(DATA_W));
  assign par_smp    = bit_smp && pen_q && (slot == SLOT_W'(DATA_W + 1));
  assign stop_smp   = bit_smp && (slot == SLOT_W'(stop_slot(pen_q, DATA_W)));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_HUNT:    if (hunt_edge) st_nx = ST_START;
      ST_START:   if (glitch_evt) st_nx = ST_HUNT;
                  else if (accept_evt) st_nx = ST_FRAME;
      ST_FRAME:   if (stop_smp) st_nx = rx_s ? ST_HUNT : ST_WAIT_HI;
      ST_WAIT_HI: if (rx_s) st_nx = ST_HUNT;
      default:    st_nx = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      slot      <= '0;
      pen_q     <= 1'b0;
      podd_q    <= 1'b0;
      par_bit_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept_evt) begin
        slot   <= '0;
        pen_q  <= par_en;
        podd_q <= par_odd;
      end else if (bit_smp) begin
        slot <= slot + SLOT_W'(1);
      end
      if (par_smp) par_bit_q <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= stop_smp;
      if (stop_smp) begin
        rx_data <= word;
        rx_perr <= pen_q && (par_bit_q != exp_parity(RX_MAX_W'(word), podd_q));
        rx_ferr <= !rx_s;
      end
    end
  end

  // run of consecutive low ticks on the synchronized line, for the checks
  logic [LR_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (smp_tick) begin
      if (rx_s) low_run <= '0;
      else if (low_run != LR_W'(OSR)) low_run <= low_run + LR_W'(1);
    end
  end

  a_r2_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (low_run >= LR_W'(OSR/2 - 1)));

  a_r3_glitch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_evt |=> !rx_valid);

  a_r4_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(smp_tick));

  a_r5_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_ferr_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ferr) |-> (st == ST_WAIT_HI));

  a_r7_no_rearm_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT_HI && !rx_s) |=> (st == ST_WAIT_HI));

  a_r8_clean_rehunt: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ferr) |-> (st == ST_HUNT));

endmodule

// File: tb/test_osr_uart_rx.sv
module test_osr_uart_rx;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, pen = 1'b0, podd = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_perr, rx_ferr;

  osr_uart_rx i_osr_uart_rx (
    .clk(clk), .rst_n(rst_n), .smp_tick(tick), .rxd(rxd), .par_en(pen), .par_odd(podd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always #2 clk = ~clk;

  typedef struct { logic [7:0] d; logic pe; logic fe; string tag; } exp_t;
  exp_t sbq[$];
  exp_t e;
  int checks = 0, fails = 0, got = 0;
  bit done = 0;

  // tick every fourth clock, driven on the falling edge
  int tc = 0;
  initial forever begin
    @(negedge clk);
    tick = (tc == 3);
    tc = (tc + 1) % 4;
  end

  // monitor: every strobe (R5) pops one expected character
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      got++;
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL R3 or R7: unexpected character %h pe=%b fe=%b, expected none", rx_data, rx_perr, rx_ferr);
      end else begin
        e = sbq.pop_front();
        if (rx_data !== e.d || rx_perr !== e.pe || rx_ferr !== e.fe) begin
          fails++;
          $display("FAIL %s: got %h pe=%b fe=%b, expected %h pe=%b fe=%b",
                   e.tag, rx_data, rx_perr, rx_ferr, e.d, e.pe, e.fe);
        end
      end
    end
  end

  task automatic hold(input logic lvl, input int ticks);
    rxd = lvl;
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic p_en, input logic odd,
                      input logic bad_par, input logic stop_lvl, input string tag);
    exp_t x;
    pen = p_en; podd = odd;
    x.d = d; x.pe = p_en & bad_par; x.fe = ~stop_lvl; x.tag = tag;
    sbq.push_back(x);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(d[i], 16);
    if (p_en) hold((^d) ^ odd ^ bad_par, 16);
    hold(stop_lvl, 16);
  endtask

  task automatic expect_count(input int n, input string tag);
    checks++;
    if (got != n) begin
      fails++;
      $display("FAIL %s: characters received %0d, expected %0d", tag, got, n);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (rx_valid !== 1'b0 || rx_data !== 8'h00 || rx_perr !== 1'b0 || rx_ferr !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid=%b data=%h pe=%b fe=%b, expected 0 00 0 0", rx_valid, rx_data, rx_perr, rx_ferr);
    end
    hold(1'b1, 20);

    // R4 data patterns, no parity
    send(8'h00, 0, 0, 0, 1, "R4"); hold(1'b1, 8);
    send(8'hFF, 0, 0, 0, 1, "R4"); hold(1'b1, 8);
    send(8'hA5, 0, 0, 0, 1, "R4"); hold(1'b1, 8);
    send(8'h01, 0, 0, 0, 1, "R4"); hold(1'b1, 8);
    send(8'h80, 0, 0, 0, 1, "R4"); hold(1'b1, 8);

    // R6 parity, even and odd, good and bad
    send(8'hA5, 1, 0, 0, 1, "R6"); hold(1'b1, 8);
    send(8'hA5, 1, 0, 1, 1, "R6"); hold(1'b1, 8);
    send(8'h07, 1, 1, 0, 1, "R6"); hold(1'b1, 8);
    send(8'h07, 1, 1, 1, 1, "R6"); hold(1'b1, 8);
    send(8'h00, 1, 1, 0, 1, "R6"); hold(1'b1, 8);

    // R3 glitches of 7 ticks and 1 tick
    hold(1'b1, 4);
    expect_count(10, "R4");
    hold(1'b0, 7); hold(1'b1, 40);
    expect_count(10, "R3");
    hold(1'b0, 1); hold(1'b1, 24);
    expect_count(10, "R3");

    // R2 shortest accepted start: 8 low ticks then high -> 0xFF, stop high
    pen = 0; podd = 0;
    begin
      exp_t x;
      x.d = 8'hFF; x.pe = 0; x.fe = 0; x.tag = "R2";
      sbq.push_back(x);
    end
    hold(1'b0, 8); hold(1'b1, 16 * 10);
    expect_count(11, "R2");

    // R7 framing error, line held low afterwards, then a clean frame
    send(8'h3C, 0, 0, 0, 0, "R7");
    hold(1'b0, 40); hold(1'b1, 32);
    expect_count(12, "R7");
    send(8'hC3, 0, 0, 0, 1, "R7"); hold(1'b1, 8);

    // R8 back to back, single stop bit, no gap
    send(8'h12, 1, 0, 0, 1, "R8");
    send(8'h34, 1, 1, 0, 1, "R8");
    send(8'h56, 0, 0, 0, 1, "R8");
    send(8'h78, 1, 0, 1, 1, "R8");
    hold(1'b1, 32);

    checks++;
    if (sbq.size() != 0 || got != 17) begin
      fails++;
      $display("FAIL R8: %0d characters left, %0d received, expected 0 left and 17 received", sbq.size(), got);
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end
endmodule